// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block holds stores that a core has issued but not yet written to memory. Each store first reserves an entry and receives a tag. Its address (with an access size) and its data then arrive on two independent write ports, in either order, so an entry may know its address while its data is still pending, or the reverse. Entries leave in program order through a commit port once both halves are present.

A load probes every buffered store, all of which are older than it. If the youngest store that overlaps the load covers all of its bytes and has valid data, the data is forwarded straight from the buffer. A partial overlap, a matching store whose data is still pending, or any buffered store with an unknown address makes the load stall. A load that touches no buffered byte is free to read memory.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the buffer is empty: alloc_ready is 1, alloc_tag is 0, cm_valid is 0 and a probe neither forwards nor stalls.
- R2: Tags are handed out in increasing order modulo DEPTH (8) starting at 0; with DEPTH entries in use alloc_ready is 0 and an alloc request has no effect.
- R3: The address write and the data write of an entry may arrive in either order; an entry is offered for commit only after both have arrived.
- R4: Commit follows allocation order: the oldest entry blocks all younger ones until its address and data are both present.
- R5: The commit port shows the word address (low byte-offset bits zero), a byte-enable mask and the lane-aligned data; the mask for size code 0/1/2 is 1/2/4 bytes starting at the address aligned down to that size (size 3 acts as 2). While cm_ready is 0 the offered commit stays unchanged.
- R6: When the youngest overlapping store covers every load byte and has its data, ld_fwd is 1 and ld_data holds that store's lanes for the load bytes, other lanes zero.
- R7: Among several overlapping stores, the youngest one decides the outcome.
- R8: When the youngest overlapping store covers only some load bytes, ld_stall is 1 and ld_fwd is 0.
- R9: When the youngest overlapping store still lacks data, the load stalls; once the data arrives the same probe forwards.
- R10: Any buffered store with an unknown address makes every load stall.
- R11: A load with no byte in common with any buffered store (other word, or same word and other bytes) gives ld_fwd 0 and ld_stall 0.
- R12: An address or data write to a tag not in use, or to a half already written, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Reserve an entry for the next store |
| alloc_ready | output | 1 | An entry is free |
| alloc_tag | output | 3 | Tag the next reservation receives |
| sta_valid | input | 1 | Address write strobe |
| sta_tag | input | 3 | Entry receiving the address |
| sta_addr | input | 16 | Store byte address |
| sta_size | input | 2 | Store size code |
| std_valid | input | 1 | Data write strobe (one per cycle) |
| std_tag | input | 3 | Entry receiving the data |
| std_data | input | 32 | Store data, lane aligned |
| ld_valid | input | 1 | Load probe strobe |
| ld_addr | input | 16 | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_fwd | output | 1 | Load data forwarded |
| ld_stall | output | 1 | Load must wait |
| ld_data | output | 32 | Forwarded data, load lanes only |
| cm_valid | output | 1 | Oldest entry ready to write |
| cm_ready | input | 1 | Memory accepts the commit |
| cm_addr | output | 16 | Commit word address |
| cm_be | output | 4 | Commit byte enables |
| cm_data | output | 32 | Commit data |

## Verification
The bench attacks the age order of forwarding: two stores cover the same byte and only the younger may answer, while a byte covered only by the older store must still come from it; a design that scanned oldest-first would return stale data. It probes a store whose address is known but whose data is absent, and a store whose data came first, where a careless design would forward garbage or commit half an entry. It parks an incomplete entry in front of a complete one to catch out-of-order commit, and fills the buffer and pushes one more reservation to catch a tail pointer that wraps over live entries. Writes to free tags and rewrites of filled halves must leave the forwarded and committed values untouched.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
    localparam int SB_DEPTH = 8;
    localparam int SB_AW    = 16;
    localparam int SB_DW    = 32;
endpackage

// File: rtl/sb_lanes.sv
`timescale 1ns/1ps
module sb_lanes #(
    parameter int AW = sb_pkg::SB_AW,
    parameter int DW = sb_pkg::SB_DW
) (
    input  logic [AW-1:0]                 addr,
    input  logic [1:0]                    size,
    output logic [AW-$clog2(DW/8)-1:0]    waddr,
    output logic [DW/8-1:0]               mask
);
    localparam int BYTES = DW / 8;
    localparam int OFFW  = $clog2(BYTES);

    logic [OFFW-1:0] off;
    int              nlog;

    always_comb begin
        off   = addr[OFFW-1:0];
        waddr = addr[AW-1:OFFW];
        nlog  = (int'(size) > OFFW) ? OFFW : int'(size);
        for (int b = 0; b < BYTES; b++) begin
            mask[b] = ((OFFW'(b) >> nlog) == (off >> nlog));
        end
    end
endmodule

// File: rtl/sb_ring.sv
`timescale 1ns/1ps
module sb_ring #(
    parameter int DEPTH = sb_pkg::SB_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     pop,
    output logic [$clog2(DEPTH)-1:0] head,
    output logic [$clog2(DEPTH)-1:0] tail,
    output logic                     full
);
    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [PW:0]   cnt;
    } ring_t;

    ring_t ring_d, ring_q;
    logic  do_push;

    always_comb begin
        ring_d  = ring_q;
        do_push = push && (ring_q.cnt != (PW+1)'(DEPTH));
        if (do_push) ring_d.tail = ring_q.tail + 1'b1;
        if (pop)     ring_d.head = ring_q.head + 1'b1;
        ring_d.cnt = ring_q.cnt + (PW+1)'(do_push) - (PW+1)'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    assign head = ring_q.head;
    assign tail = ring_q.tail;
    assign full = (ring_q.cnt == (PW+1)'(DEPTH));

    // R2: occupancy moves by exactly one on a lone reservation
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        push && !full && !pop |=> ring_q.cnt == $past(ring_q.cnt) + 1'b1);

    // R2: a reservation while full leaves the tail where it was
    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> $stable(ring_q.tail));
endmodule

// File: rtl/sb_probe.sv
`timescale 1ns/1ps
module sb_probe #(
    parameter int DEPTH = sb_pkg::SB_DEPTH,
    parameter int AW    = sb_pkg::SB_AW,
    parameter int DW    = sb_pkg::SB_DW
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [DEPTH-1:0]                      used,
    input  logic [DEPTH-1:0]                      av,
    input  logic [DEPTH-1:0]                      dv,
    input  logic [DEPTH-1:0][AW-$clog2(DW/8)-1:0] waddr,
    input  logic [DEPTH-1:0][DW/8-1:0]            bmask,
    input  logic [DEPTH-1:0][DW-1:0]              data,
    input  logic [$clog2(DEPTH)-1:0]              head,
    input  logic                                  ld_valid,
    input  logic [AW-$clog2(DW/8)-1:0]            ld_waddr,
    input  logic [DW/8-1:0]                       ld_mask,
    output logic                                  fwd,
    output logic                                  stall,
    output logic [DW-1:0]                         fwd_data
);
    localparam int PW    = $clog2(DEPTH);
    localparam int BYTES = DW / 8;

    logic            unknown, found, covers, has_data;
    logic [DW-1:0]   pick;
    logic [PW-1:0]   idx;

    always_comb begin
        unknown  = 1'b0;
        found    = 1'b0;
        covers   = 1'b0;
        has_data = 1'b0;
        pick     = '0;
        idx      = head;
        // walk oldest to youngest so the youngest overlap is kept last
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PW'(k);
            if (used[idx]) begin
                if (!av[idx]) begin
                    unknown = 1'b1;
                end else if (waddr[idx] == ld_waddr && (bmask[idx] & ld_mask) != '0) begin
                    found    = 1'b1;
                    covers   = ((ld_mask & ~bmask[idx]) == '0);
                    has_data = dv[idx];
                    pick     = data[idx];
                end
            end
        end
        fwd   = ld_valid && !unknown && found && covers && has_data;
        stall = ld_valid && (unknown || (found && !(covers && has_data)));
        fwd_data = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (fwd && ld_mask[b]) fwd_data[8*b +: 8] = pick[8*b +: 8];
        end
    end

    // R6 R8: a probe never both forwards and stalls
    a_r8_fwd_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd && stall));

    // R11: with no buffered store there is nothing to wait for
    a_r11_empty_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (used == '0) |-> !stall);
endmodule

// File: rtl/store_fwd_buffer.sv
`timescale 1ns/1ps
module store_fwd_buffer #(
    parameter int DEPTH = sb_pkg::SB_DEPTH,
    parameter int AW    = sb_pkg::SB_AW,
    parameter int DW    = sb_pkg::SB_DW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid,
    output logic                     alloc_ready,
    output logic [$clog2(DEPTH)-1:0] alloc_tag,
    input  logic                     sta_valid,
    input  logic [$clog2(DEPTH)-1:0] sta_tag,
    input  logic [AW-1:0]            sta_addr,
    input  logic [1:0]               sta_size,
    input  logic                     std_valid,
    input  logic [$clog2(DEPTH)-1:0] std_tag,
    input  logic [DW-1:0]            std_data,
    input  logic                     ld_valid,
    input  logic [AW-1:0]            ld_addr,
    input  logic [1:0]               ld_size,
    output logic                     ld_fwd,
    output logic                     ld_stall,
    output logic [DW-1:0]            ld_data,
    output logic                     cm_valid,
    input  logic                     cm_ready,
    output logic [AW-1:0]            cm_addr,
    output logic [DW/8-1:0]          cm_be,
    output logic [DW-1:0]            cm_data
);
    localparam int PW    = $clog2(DEPTH);
    localparam int BYTES = DW / 8;
    localparam int OFFW  = $clog2(BYTES);
    localparam int WAW   = AW - OFFW;

    typedef struct packed {
        logic [DEPTH-1:0]            used;
        logic [DEPTH-1:0]            av;
        logic [DEPTH-1:0]            dv;
        logic [DEPTH-1:0][WAW-1:0]   waddr;
        logic [DEPTH-1:0][BYTES-1:0] bmask;
        logic [DEPTH-1:0][DW-1:0]    data;
    } ent_t;

    ent_t ent_d, ent_q;

    logic [PW-1:0]    head, tail;
    logic             full, push, pop;
    logic [WAW-1:0]   sta_waddr, ld_waddr;
    logic [BYTES-1:0] sta_mask, ld_mask;

    sb_lanes #(.AW(AW), .DW(DW)) u_sta_lanes (
        .addr(sta_addr), .size(sta_size), .waddr(sta_waddr), .mask(sta_mask));

    sb_lanes #(.AW(AW), .DW(DW)) u_ld_lanes (
        .addr(ld_addr), .size(ld_size), .waddr(ld_waddr), .mask(ld_mask));

    sb_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .head(head), .tail(tail), .full(full));

    sb_probe #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_probe (
        .clk(clk), .rst_n(rst_n),
        .used(ent_q.used), .av(ent_q.av), .dv(ent_q.dv),
        .waddr(ent_q.waddr), .bmask(ent_q.bmask), .data(ent_q.data),
        .head(head), .ld_valid(ld_valid), .ld_waddr(ld_waddr), .ld_mask(ld_mask),
        .fwd(ld_fwd), .stall(ld_stall), .fwd_data(ld_data));

    assign alloc_ready = !full;
    assign alloc_tag   = tail;
    assign push        = alloc_valid && !full;
    assign cm_valid    = ent_q.used[head] && ent_q.av[head] && ent_q.dv[head];
    assign pop         = cm_valid && cm_ready;
    assign cm_addr     = {ent_q.waddr[head], OFFW'(0)};
    assign cm_be       = ent_q.bmask[head];
    assign cm_data     = ent_q.data[head];

    always_comb begin
        ent_d = ent_q;
        if (pop) begin
            ent_d.used[head] = 1'b0;
            ent_d.av[head]   = 1'b0;
            ent_d.dv[head]   = 1'b0;
        end
        if (push) begin
            ent_d.used[tail] = 1'b1;
            ent_d.av[tail]   = 1'b0;
            ent_d.dv[tail]   = 1'b0;
        end
        // each half is written once, and only into a live entry
        if (sta_valid && ent_d.used[sta_tag] && !ent_d.av[sta_tag]) begin
            ent_d.av[sta_tag]    = 1'b1;
            ent_d.waddr[sta_tag] = sta_waddr;
            ent_d.bmask[sta_tag] = sta_mask;
        end
        if (std_valid && ent_d.used[std_tag] && !ent_d.dv[std_tag]) begin
            ent_d.dv[std_tag]   = 1'b1;
            ent_d.data[std_tag] = std_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    // R5: a refused commit is offered again unchanged
    a_r5_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid && !cm_ready |=> cm_valid && $stable(cm_addr) && $stable(cm_be) && $stable(cm_data));

    // R4: the head only moves through an accepted commit
    a_r4_head_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !(cm_valid && cm_ready) |=> $stable(head));
endmodule

// File: tb/sim_store_fwd_buffer.sv
`timescale 1ns/1ps
module sim_store_fwd_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0, sta_valid = 0, std_valid = 0, ld_valid = 0, cm_ready = 0;
    logic [2:0]  sta_tag = 0, std_tag = 0, alloc_tag;
    logic [15:0] sta_addr = 0, ld_addr = 0, cm_addr;
    logic [1:0]  sta_size = 0, ld_size = 0;
    logic [31:0] std_data = 0, ld_data, cm_data;
    logic        alloc_ready, ld_fwd, ld_stall, cm_valid;
    logic [3:0]  cm_be;

    int total = 0, bad = 0, commits = 0;
    int exp_q[$];
    logic [15:0] e_addr [8];
    logic [3:0]  e_be   [8];
    logic [31:0] e_data [8];

    always #4 clk = ~clk;

    store_fwd_buffer u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .sta_valid(sta_valid), .sta_tag(sta_tag), .sta_addr(sta_addr), .sta_size(sta_size),
        .std_valid(std_valid), .std_tag(std_tag), .std_data(std_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
        .ld_fwd(ld_fwd), .ld_stall(ld_stall), .ld_data(ld_data),
        .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_addr(cm_addr),
        .cm_be(cm_be), .cm_data(cm_data));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_alloc(output int t);
        @(negedge clk);
        alloc_valid = 1;
        #1;
        t = alloc_tag;
        if (alloc_ready) exp_q.push_back(t);
        @(posedge clk);
        #1 alloc_valid = 0;
    endtask

    task automatic do_sta(input int t, input logic [15:0] a, input logic [1:0] s,
                          input logic [3:0] be, input bit rec);
        @(negedge clk);
        sta_valid = 1; sta_tag = 3'(t); sta_addr = a; sta_size = s;
        if (rec) begin e_addr[t] = {a[15:2], 2'b00}; e_be[t] = be; end
        @(posedge clk);
        #1 sta_valid = 0;
    endtask

    task automatic do_std(input int t, input logic [31:0] d, input bit rec);
        @(negedge clk);
        std_valid = 1; std_tag = 3'(t); std_data = d;
        if (rec) e_data[t] = d;
        @(posedge clk);
        #1 std_valid = 0;
    endtask

    task automatic probe(input logic [15:0] a, input logic [1:0] s, input bit ef,
                         input bit es, input logic [31:0] ed, input string req);
        @(negedge clk);
        ld_valid = 1; ld_addr = a; ld_size = s;
        #1;
        chk(ld_fwd == ef, req, "ld_fwd", 32'(ld_fwd), 32'(ef));
        chk(ld_stall == es, req, "ld_stall", 32'(ld_stall), 32'(es));
        if (ef) chk(ld_data == ed, req, "ld_data", ld_data, ed);
        ld_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor: compares every accepted commit with the oldest expectation
    always @(negedge clk) begin
        #2;
        if (rst_n && cm_valid && cm_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R4", "unexpected commit", 32'(cm_addr), 0);
            end else begin
                int t;
                t = exp_q.pop_front();
                commits++;
                chk(cm_addr == e_addr[t], "R5", "cm_addr", 32'(cm_addr), 32'(e_addr[t]));
                chk(cm_be == e_be[t], "R5", "cm_be", 32'(cm_be), 32'(e_be[t]));
                chk(cm_data == e_data[t], "R5", "cm_data", cm_data, e_data[t]);
            end
        end
    end

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(alloc_ready == 1, "R1", "alloc_ready", 32'(alloc_ready), 1);
        chk(alloc_tag == 0, "R1", "alloc_tag", 32'(alloc_tag), 0);
        chk(cm_valid == 0, "R1", "cm_valid", 32'(cm_valid), 0);
        probe(16'h0100, 2'd2, 0, 0, 0, "R1");

        // R3: data before address, commit parked by cm_ready=0
        do_alloc(t);
        chk(t == 0, "R2", "first tag", 32'(t), 0);
        do_std(0, 32'h11223344, 1);
        idle(1);
        chk(cm_valid == 0, "R3", "cm_valid data only", 32'(cm_valid), 0);
        do_sta(0, 16'h0100, 2'd2, 4'hF, 1);
        @(negedge clk); #1;
        chk(cm_valid == 1, "R3", "cm_valid both halves", 32'(cm_valid), 1);
        chk(cm_addr == 16'h0100 && cm_be == 4'hF && cm_data == 32'h11223344,
            "R5", "offered commit", cm_data, 32'h11223344);
        @(negedge clk); #1;
        chk(cm_valid == 1 && cm_addr == 16'h0100 && cm_data == 32'h11223344,
            "R5", "commit held", cm_data, 32'h11223344);

        // t1: one byte at offset 1, data pending
        do_alloc(t);
        chk(t == 1, "R2", "second tag", 32'(t), 1);
        do_sta(1, 16'h0101, 2'd0, 4'b0010, 1);
        probe(16'h0100, 2'd2, 0, 1, 0, "R8");
        probe(16'h0100, 2'd1, 0, 1, 0, "R8");
        probe(16'h0101, 2'd0, 0, 1, 0, "R9");
        do_std(1, 32'h0000AB00, 1);
        probe(16'h0101, 2'd0, 1, 0, 32'h0000AB00, "R9");
        probe(16'h0101, 2'd0, 1, 0, 32'h0000AB00, "R7");
        probe(16'h0102, 2'd0, 1, 0, 32'h00220000, "R6");
        probe(16'h0200, 2'd2, 0, 0, 0, "R11");

        // t2: unknown address stalls everything
        do_alloc(t);
        probe(16'h0200, 2'd2, 0, 1, 0, "R10");
        do_sta(2, 16'h0202, 2'd1, 4'b1100, 1);
        do_sta(2, 16'h0400, 2'd2, 4'hF, 0);
        do_std(2, 32'h55660000, 1);
        probe(16'h0202, 2'd1, 1, 0, 32'h55660000, "R12");
        probe(16'h0400, 2'd2, 0, 0, 0, "R12");
        probe(16'h0200, 2'd0, 0, 0, 0, "R11");

        // t3 missing data, t4 complete, t5 with an early data write to a free tag
        do_std(5, 32'hBAD0BAD0, 0);
        do_alloc(t);
        do_sta(3, 16'h0300, 2'd2, 4'hF, 1);
        do_alloc(t);
        do_sta(4, 16'h0304, 2'd2, 4'hF, 1);
        do_std(4, 32'hDEADBEEF, 1);
        do_alloc(t);
        chk(t == 5, "R2", "sixth tag", 32'(t), 5);
        do_sta(5, 16'h0308, 2'd2, 4'hF, 1);
        probe(16'h0308, 2'd2, 0, 1, 0, "R12");

        // R4: drain stops at the incomplete t3
        @(negedge clk); cm_ready = 1;
        idle(6);
        #1;
        chk(commits == 3, "R4", "commits before block", 32'(commits), 3);
        chk(cm_valid == 0, "R4", "blocked head", 32'(cm_valid), 0);
        do_std(3, 32'hA5A5A5A5, 1);
        idle(4);
        chk(commits == 5, "R4", "commits after unblock", 32'(commits), 5);
        do_std(5, 32'h01020304, 1);
        idle(3);
        #1;
        chk(commits == 6, "R4", "all drained", 32'(commits), 6);
        chk(alloc_tag == 6, "R2", "tag after drain", 32'(alloc_tag), 6);

        // R2: fill, push once more while full, then free one entry
        @(negedge clk); cm_ready = 0;
        for (int i = 0; i < 8; i++) begin
            do_alloc(t);
            chk(t == (6 + i) % 8, "R2", "fill tag", 32'(t), 32'((6 + i) % 8));
        end
        #1;
        chk(alloc_ready == 0, "R2", "full alloc_ready", 32'(alloc_ready), 0);
        do_alloc(t);
        do_sta(6, 16'h0500, 2'd2, 4'hF, 1);
        do_std(6, 32'h0BADF00D, 1);
        @(negedge clk); cm_ready = 1;
        idle(2);
        #1;
        chk(alloc_ready == 1, "R2", "ready after commit", 32'(alloc_ready), 1);
        chk(alloc_tag == 6, "R2", "tail not moved while full", 32'(alloc_tag), 6);
        for (int i = 1; i < 8; i++) begin
            do_sta((6 + i) % 8, 16'(16'h0600 + 4 * i), 2'd2, 4'hF, 1);
            do_std((6 + i) % 8, 32'(32'hC0DE0000 + i), 1);
        end
        idle(4);
        #1;
        chk(commits == 14, "R4", "final commit count", 32'(commits), 14);
        chk(exp_q.size() == 0, "R4", "scoreboard empty", 32'(exp_q.size()), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule